// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register

This block is a parameterised register (eight stages by default) that sits between two parallel buses, called A and B, inside a larger chip. It has a serial data input and an external shift clock, and four mode controls. A direction control picks which bus is the source and which bus the register drives. An A-side enable can take bus A off line completely. A parallel/serial select picks between loading a bus word and shifting in serial data. A transparency select picks between loading on the external clock and following the source bus.

Each bus is split into an input vector, an output vector and an output-enable vector. The output vectors always carry the register contents, and the enable vectors mark which bus is actually driven. Everything runs on a fast system clock. The external shift clock is sampled in the system clock domain and only its rising transitions act. The transparent load is built as a capture on every system clock cycle. The last stage is brought out as a serial output so that instances can be chained.

Top module: `bus_xfer_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage to zero and holds both output-enable vectors at zero.
- R2: With dirAtoB high, bOe is all ones, aOe is all zeros, and bOut shows the register contents.
- R3: With dirAtoB low, bOe is all zeros. aOe is all ones when aEnable is high and all zeros when aEnable is low, in both parallel and serial mode.
- R4: aOe and bOe are each all ones or all zeros, and they are never enabled at the same time.
- R5: In clocked parallel mode (parMode high, transparent low), the source bus is captured on each sampled rising edge of extClk: bus A when dirAtoB is high, bus B when it is low. Without such an edge the register holds.
- R6: In parallel mode with dirAtoB high and aEnable low, bus A is not captured, even on an extClk rising edge.
- R7: In serial mode (parMode low), each extClk rising edge moves serIn into stage 0 (bit 0) and moves every stage up by one bit position. serOut is the top bit.
- R8: In transparent parallel mode (parMode and transparent both high), the register takes the source bus on every system clock cycle. The driven output therefore tracks the source with one cycle of lag and needs no extClk edge.
- R9: In serial mode, the transparent select and both bus inputs have no effect. The register changes only on an extClk rising edge.
- R10: An extClk that is held high causes exactly one action. A further shift or load needs a new low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| extClk | input | 1 | External shift/load clock, sampled by clk |
| serIn | input | 1 | Serial data entering stage 0 |
| aEnable | input | 1 | Enables bus A as source and as output |
| dirAtoB | input | 1 | 1: A is source and B is driven; 0: B is source and A is driven |
| parMode | input | 1 | 1: parallel load; 0: serial shift |
| transparent | input | 1 | In parallel mode, 1 loads every clk cycle |
| aIn | input | W | Bus A input lines |
| aOut | output | W | Bus A output lines |
| aOe | output | W | Bus A output enables |
| bIn | input | W | Bus B input lines |
| bOut | output | W | Bus B output lines |
| bOe | output | W | Bus B output enables |
| serOut | output | 1 | Top stage, for chaining |

## Verification
The edge detector and the register each add one flop, so a level on extClk applied between clk edges is acted on at the next clk rising edge. The new contents are visible on aOut, bOut and serOut right after that edge. A transparent load likewise appears one clk cycle after the source bus changes. The output enables follow the mode inputs combinationally, with no cycle of delay.

The bench drives inputs on the falling edge of clk and samples one falling edge after the rising edge that should act. Hold checks sample after the extra cycles in which nothing may change.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef struct packed {
    logic shift;
    logic loadA;
    logic loadB;
    logic driveA;
    logic driveB;
  } bxrStrobe_t;
endpackage

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
  import bxr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       extClk,
  input  logic       aEnable,
  input  logic       dirAtoB,
  input  logic       parMode,
  input  logic       transparent,
  output bxrStrobe_t strb
);
  logic extQ;
  logic extRise;
  logic loadEvent;

  always_ff @(posedge clk) begin
    if (rst) extQ <= 1'b0;
    else     extQ <= extClk;
  end

  assign extRise   = extClk & ~extQ;
  assign loadEvent = parMode & (transparent | extRise);

  always_comb begin
    strb        = '0;
    strb.shift  = ~parMode & extRise;
    strb.loadA  = loadEvent & dirAtoB & aEnable;
    strb.loadB  = loadEvent & ~dirAtoB;
    strb.driveA = aEnable & ~dirAtoB;
    strb.driveB = dirAtoB;
  end

  // R10
  held_clk_no_act_chk: assert property (@(posedge clk) disable iff (rst)
    (extClk && extQ && !(parMode && transparent)) |-> !(strb.shift || strb.loadA || strb.loadB));

  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shift, strb.loadA, strb.loadB}));
endmodule

// File: rtl/bxr_path.sv
module bxr_path
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  bxrStrobe_t   strb,
  input  logic         serIn,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] stage,
  output logic [W-1:0] aOe,
  output logic [W-1:0] bOe
);
  localparam int TOP = W - 1;

  logic [W-1:0] shiftVec;
  assign shiftVec = {stage[TOP-1:0], serIn};

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic q;
    always_ff @(posedge clk) begin
      if (rst)             q <= 1'b0;
      else if (strb.shift) q <= shiftVec[i];
      else if (strb.loadA) q <= aIn[i];
      else if (strb.loadB) q <= bIn[i];
    end
    assign stage[i] = q;
  end

  assign aOe = {W{strb.driveA & ~rst}};
  assign bOe = {W{strb.driveB & ~rst}};

  // R4
  oe_exclusive_chk: assert property (@(posedge clk)
    !((|aOe) && (|bOe)) && (aOe == '0 || &aOe) && (bOe == '0 || &bOe));

  // R7
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> stage == {$past(stage[TOP-1:0]), $past(serIn)});

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.shift || strb.loadA || strb.loadB) |=> $stable(stage));
endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         extClk,
  input  logic         serIn,
  input  logic         aEnable,
  input  logic         dirAtoB,
  input  logic         parMode,
  input  logic         transparent,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic [W-1:0] bOe,
  output logic         serOut
);
  bxrStrobe_t   strb;
  logic [W-1:0] stage;

  bxr_ctrl ctrl_i (
    .clk(clk), .rst(rst), .extClk(extClk), .aEnable(aEnable),
    .dirAtoB(dirAtoB), .parMode(parMode), .transparent(transparent),
    .strb(strb)
  );

  bxr_path #(.W(W)) path_i (
    .clk(clk), .rst(rst), .strb(strb), .serIn(serIn),
    .aIn(aIn), .bIn(bIn), .stage(stage), .aOe(aOe), .bOe(bOe)
  );

  assign aOut   = stage;
  assign bOut   = stage;
  assign serOut = stage[W-1];
endmodule

// File: tb/bus_xfer_reg_tb_top.sv
module bus_xfer_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extClk = 1'b0, serIn = 1'b0, aEnable = 1'b0, dirAtoB = 1'b0;
  logic parMode = 1'b0, transparent = 1'b0;
  logic [7:0] aIn = '0, bIn = '0;
  logic [7:0] aOut, aOe, bOut, bOe;
  logic serOut;
  int total = 0;
  int bad = 0;
  logic [7:0] expReg = '0;

  always #5 clk = ~clk;

  bus_xfer_reg #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .extClk(extClk), .serIn(serIn), .aEnable(aEnable),
    .dirAtoB(dirAtoB), .parMode(parMode), .transparent(transparent),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .serOut(serOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse();
    extClk = 1'b1;
    tick();
    extClk = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; dirAtoB = 1'b1;
    tick(); tick();
    chk("R1 aOe in reset", aOe, 8'h00);
    chk("R1 bOe in reset", bOe, 8'h00);
    rst = 1'b0;
    tick();
    chk("R1 cleared stages", bOut, 8'h00);
  endtask

  task automatic t_clocked_load();
    aEnable = 1'b1; dirAtoB = 1'b1; parMode = 1'b1; transparent = 1'b0;
    aIn = 8'hA5;
    tick(); tick();
    chk("R5 no edge holds", bOut, 8'h00);
    pulse();
    chk("R5 A captured", bOut, 8'hA5);
    chk("R2 bOe", bOe, 8'hFF);
    chk("R2 aOe", aOe, 8'h00);
    dirAtoB = 1'b0; bIn = 8'h3C;
    #1;
    chk("R3 aOe enabled", aOe, 8'hFF);
    chk("R4 bOe off", bOe, 8'h00);
    pulse();
    chk("R5 B captured", aOut, 8'h3C);
    aEnable = 1'b0;
    #1;
    chk("R3 aOe disabled", aOe, 8'h00);
    dirAtoB = 1'b1; aIn = 8'h0F;
    pulse();
    chk("R6 A disabled not captured", bOut, 8'h3C);
  endtask

  task automatic t_shift();
    logic [7:0] pat = 8'b0100_1101;
    parMode = 1'b0; aEnable = 1'b0; dirAtoB = 1'b1; expReg = 8'h3C;
    for (int i = 0; i < 8; i++) begin
      serIn = pat[i];
      pulse();
      expReg = {expReg[6:0], pat[i]};
      chk("R7 shift word", bOut, expReg);
      chk("R7 serOut", {7'b0, serOut}, {7'b0, expReg[7]});
    end
    serIn = 1'b1; extClk = 1'b1;
    tick();
    expReg = {expReg[6:0], 1'b1};
    serIn = 1'b0;
    tick(); tick(); tick();
    extClk = 1'b0;
    tick();
    chk("R10 held clock single shift", bOut, expReg);
    transparent = 1'b1; aIn = 8'h77; bIn = 8'h99;
    tick(); tick();
    chk("R9 serial ignores transparent and buses", bOut, expReg);
    transparent = 1'b0;
    dirAtoB = 1'b0;
    #1;
    chk("R3 serial both undriven aOe", aOe, 8'h00);
    chk("R3 serial both undriven bOe", bOe, 8'h00);
  endtask

  task automatic t_transparent();
    parMode = 1'b1; transparent = 1'b1; aEnable = 1'b1; dirAtoB = 1'b1;
    aIn = 8'h11;
    tick();
    chk("R8 follow first", bOut, 8'h11);
    aIn = 8'h22;
    #1;
    chk("R8 one cycle lag", bOut, 8'h11);
    tick();
    chk("R8 follow second", bOut, 8'h22);
    dirAtoB = 1'b0; bIn = 8'hE7;
    tick();
    chk("R8 follow bus B", aOut, 8'hE7);
    transparent = 1'b0;
    rst = 1'b1;
    tick();
    chk("R1 reset clears", aOut, 8'h00);
    chk("R1 reset aOe", aOe, 8'h00);
    rst = 1'b0;
  endtask

  initial begin
    tick();
    t_reset();
    t_clocked_load();
    t_shift();
    t_transparent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule